// File: doc/BRIEF.md
# Code Segment Register Loader

This block updates the code segment register of a segmented processor model. It holds the visible 16-bit selector and a hidden shadow copy of the segment: base, limit and a set of attribute bits (privilege level, readable, writable, expand-down, conforming, 32-bit default size). A load is requested with a one-cycle `start` pulse. With the pulse come the new selector, the mode flags, the current privilege level and a descriptor that an outside fetch unit has already read and decoded. The fetch unit also reports whether the selector points past the end of its descriptor table.

When protection is off, or the virtual-8086 flag is set, the load is an address-arithmetic load. The base is derived from the selector, the limit is left as it was, and the attributes take fixed values. In protected mode the descriptor is checked for being code, for privilege and for presence, in that order. The first failing check produces a general-protection or not-present fault, and the shadow register is left untouched. A successful protected load copies the descriptor into the shadow register and replaces the selector's requested privilege bits with the current privilege level. When the descriptor's accessed flag is still clear, the block also asks for a one-byte write-back that sets it.

Top module: `cs_loader`

## Requirements
- R1: Every `start` pulse is followed on the next cycle by a single-cycle `done`. `done` is low in every other cycle, and the register keeps its value in cycles without `start`.
- R2: With `prot_en`=0 or `v86`=1, a load latches the selector unchanged and sets the base to the selector shifted left by 4. The limit keeps its previous value. No fault is reported, even when `outside_tbl` is set.
- R3: Such a load sets readable=1, writable=1, expand-down=0, conforming=0 and big=0. DPL becomes 3 when `v86`=1 and 0 otherwise.
- R4: In protected mode (`prot_en`=1, `v86`=0), `outside_tbl`=1 gives `fault_kind`=1 (general protection). `err_code` is then the selector with bits 1:0 cleared. It is 0 on every load without a fault.
- R5: In protected mode, a descriptor whose access byte does not have both bit 4 (non-system) and bit 3 (code) set gives `fault_kind`=1.
- R6: For conforming code (access byte bit 2 = 1), a DPL (bits 6:5) greater than `cpl` gives `fault_kind`=1. A DPL at or below `cpl` passes this check, whatever the selector RPL (bits 1:0).
- R7: For non-conforming code, an RPL greater than `cpl` or a DPL not equal to `cpl` gives `fault_kind`=1.
- R8: A descriptor that passes R4 to R7 but has access byte bit 7 (present) clear gives `fault_kind`=2 (not present).
- R9: On any fault the selector, base, limit and attributes keep their values and no write-back is requested.
- R10: A successful protected load latches the selector with bits 1:0 replaced by `cpl`. Base, limit, DPL, readable (bit 1), conforming (bit 2) and big come from the descriptor, and writable and expand-down are 0.
- R11: A successful protected load whose access byte has bit 0 (accessed) clear pulses `ab_wr_en` together with `done`. The address is `desc_addr`+5 and the data is the access byte with bit 0 set. With bit 0 already set, no write-back is requested.
- R12: After reset the register holds selector 0, base 0, limit 0xFFFF, DPL 0, readable=1, writable=1 and all other attributes 0. `done` and `ab_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load request, one cycle |
| new_sel | input | 16 | Selector to load |
| prot_en | input | 1 | Protection enabled |
| v86 | input | 1 | Virtual-8086 mode |
| cpl | input | 2 | Current privilege level |
| outside_tbl | input | 1 | Selector lies beyond the descriptor table |
| desc_addr | input | ADDR_W | Address of the descriptor |
| desc_base | input | BASE_W | Descriptor base |
| desc_limit | input | LIMIT_W | Descriptor limit (already scaled) |
| desc_ar | input | 8 | Descriptor access byte |
| desc_big | input | 1 | Descriptor default-size bit |
| done | output | 1 | Load finished |
| fault_kind | output | 2 | 0 none, 1 general protection, 2 not present |
| err_code | output | 16 | Fault error code |
| cs_sel | output | 16 | Visible selector |
| cs_base | output | BASE_W | Shadow base |
| cs_limit | output | LIMIT_W | Shadow limit |
| cs_dpl | output | 2 | Shadow DPL |
| cs_rd | output | 1 | Readable |
| cs_wr | output | 1 | Writable |
| cs_exp_dn | output | 1 | Expand-down |
| cs_conf | output | 1 | Conforming |
| cs_big | output | 1 | 32-bit default size |
| ab_wr_en | output | 1 | Accessed-bit write-back request |
| ab_wr_addr | output | ADDR_W | Write-back byte address |
| ab_wr_data | output | 8 | Write-back byte |

## Verification
On every cycle the assertions check several properties: the start-to-done timing, that a faulting load leaves the register alone, the base arithmetic of unprotected loads, the privilege stamping of the selector, and that a write-back only comes with a clean completion and a set accessed bit. The ordering between the fault checks needs the bench's scenarios to show. These cover present-bit faults hidden behind privilege faults, a set `outside_tbl` that has no effect in virtual-8086 mode, and the exact fault kind chosen for each descriptor type and privilege combination. Those scenarios are compared against an independent model over random and directed loads.

// File: rtl/cs_loader_pkg.sv
package cs_loader_pkg;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_GP   = 2'd1,
        FK_NP   = 2'd2
    } fault_e;

    typedef struct packed {
        logic [1:0] dpl;
        logic       rd;
        logic       wr;
        logic       exp_dn;
        logic       conf;
        logic       big;
    } cs_attr_t;

    // access byte bit positions
    localparam int AR_PRESENT = 7;
    localparam int AR_DPL_HI  = 6;
    localparam int AR_DPL_LO  = 5;
    localparam int AR_NONSYS  = 4;
    localparam int AR_CODE    = 3;
    localparam int AR_CONF    = 2;
    localparam int AR_READ    = 1;
    localparam int AR_ACC     = 0;

    localparam logic [3:0] AR_BYTE_OFS = 4'd5;

endpackage

// File: rtl/cs_gate.sv
module cs_gate
    import cs_loader_pkg::*;
(
    input  logic        prot,
    input  logic [1:0]  cpl,
    input  logic [15:0] sel,
    input  logic        outside,
    input  logic [7:0]  ar,
    output fault_e      fault
);
    logic       is_code;
    logic       is_conf;
    logic [1:0] dpl;
    logic [1:0] rpl;
    logic       priv_bad;

    always_comb begin
        is_code  = ar[AR_NONSYS] & ar[AR_CODE];
        is_conf  = ar[AR_CONF];
        dpl      = ar[AR_DPL_HI:AR_DPL_LO];
        rpl      = sel[1:0];
        if (is_conf) begin
            priv_bad = (dpl > cpl);
        end else begin
            priv_bad = (rpl > cpl) || (dpl != cpl);
        end

        if (!prot) begin
            fault = FK_NONE;
        end else if (outside) begin
            fault = FK_GP;
        end else if (!is_code) begin
            fault = FK_GP;
        end else if (priv_bad) begin
            fault = FK_GP;
        end else if (!ar[AR_PRESENT]) begin
            fault = FK_NP;
        end else begin
            fault = FK_NONE;
        end
    end
endmodule

// File: rtl/cs_shadow_next.sv
module cs_shadow_next
    import cs_loader_pkg::*;
#(
    parameter int BASE_W  = 32,
    parameter int LIMIT_W = 32
) (
    input  logic               prot,
    input  logic               v86,
    input  logic [1:0]         cpl,
    input  logic [15:0]        sel,
    input  logic [BASE_W-1:0]  desc_base,
    input  logic [LIMIT_W-1:0] desc_limit,
    input  logic [7:0]         ar,
    input  logic               big,
    input  logic [LIMIT_W-1:0] cur_limit,
    output logic [15:0]        nxt_sel,
    output logic [BASE_W-1:0]  nxt_base,
    output logic [LIMIT_W-1:0] nxt_limit,
    output cs_attr_t           nxt_attr
);
    localparam int PAD_W = BASE_W - 20;

    logic [BASE_W-1:0] shifted_base;

    generate
        if (PAD_W > 0) begin : g_pad
            assign shifted_base = {{PAD_W{1'b0}}, sel, 4'b0000};
        end else begin : g_nopad
            assign shifted_base = {sel, 4'b0000};
        end
    endgenerate

    always_comb begin
        if (prot) begin
            nxt_sel         = {sel[15:2], cpl};
            nxt_base        = desc_base;
            nxt_limit       = desc_limit;
            nxt_attr.dpl    = ar[AR_DPL_HI:AR_DPL_LO];
            nxt_attr.rd     = ar[AR_READ];
            nxt_attr.wr     = 1'b0;
            nxt_attr.exp_dn = 1'b0;
            nxt_attr.conf   = ar[AR_CONF];
            nxt_attr.big    = big;
        end else begin
            nxt_sel         = sel;
            nxt_base        = shifted_base;
            nxt_limit       = cur_limit;
            nxt_attr.dpl    = v86 ? 2'd3 : 2'd0;
            nxt_attr.rd     = 1'b1;
            nxt_attr.wr     = 1'b1;
            nxt_attr.exp_dn = 1'b0;
            nxt_attr.conf   = 1'b0;
            nxt_attr.big    = 1'b0;
        end
    end
endmodule

// File: rtl/cs_loader.sv
module cs_loader
    import cs_loader_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BASE_W  = 32,
    parameter int LIMIT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [15:0]        new_sel,
    input  logic               prot_en,
    input  logic               v86,
    input  logic [1:0]         cpl,
    input  logic               outside_tbl,
    input  logic [ADDR_W-1:0]  desc_addr,
    input  logic [BASE_W-1:0]  desc_base,
    input  logic [LIMIT_W-1:0] desc_limit,
    input  logic [7:0]         desc_ar,
    input  logic               desc_big,
    output logic               done,
    output logic [1:0]         fault_kind,
    output logic [15:0]        err_code,
    output logic [15:0]        cs_sel,
    output logic [BASE_W-1:0]  cs_base,
    output logic [LIMIT_W-1:0] cs_limit,
    output logic [1:0]         cs_dpl,
    output logic               cs_rd,
    output logic               cs_wr,
    output logic               cs_exp_dn,
    output logic               cs_conf,
    output logic               cs_big,
    output logic               ab_wr_en,
    output logic [ADDR_W-1:0]  ab_wr_addr,
    output logic [7:0]         ab_wr_data
);
    localparam logic [LIMIT_W-1:0] RST_LIMIT = LIMIT_W'(16'hFFFF);

    typedef struct packed {
        logic               done;
        fault_e             fault;
        logic [15:0]        err;
        logic [15:0]        sel;
        logic [BASE_W-1:0]  base;
        logic [LIMIT_W-1:0] limit;
        cs_attr_t           attr;
        logic               ab_en;
        logic [ADDR_W-1:0]  ab_addr;
        logic [7:0]         ab_data;
    } state_t;

    state_t st_d, st_q;

    logic               prot;
    fault_e             fault;
    logic [15:0]        nxt_sel;
    logic [BASE_W-1:0]  nxt_base;
    logic [LIMIT_W-1:0] nxt_limit;
    cs_attr_t           nxt_attr;

    assign prot = prot_en & ~v86;

    cs_gate i_gate (
        .prot    (prot),
        .cpl     (cpl),
        .sel     (new_sel),
        .outside (outside_tbl),
        .ar      (desc_ar),
        .fault   (fault)
    );

    cs_shadow_next #(
        .BASE_W  (BASE_W),
        .LIMIT_W (LIMIT_W)
    ) i_next (
        .prot       (prot),
        .v86        (v86),
        .cpl        (cpl),
        .sel        (new_sel),
        .desc_base  (desc_base),
        .desc_limit (desc_limit),
        .ar         (desc_ar),
        .big        (desc_big),
        .cur_limit  (st_q.limit),
        .nxt_sel    (nxt_sel),
        .nxt_base   (nxt_base),
        .nxt_limit  (nxt_limit),
        .nxt_attr   (nxt_attr)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.fault   = FK_NONE;
        st_d.err     = '0;
        st_d.ab_en   = 1'b0;
        st_d.ab_addr = '0;
        st_d.ab_data = '0;
        if (start) begin
            st_d.done  = 1'b1;
            st_d.fault = fault;
            if (fault != FK_NONE) begin
                st_d.err = {new_sel[15:2], 2'b00};
            end else begin
                st_d.sel   = nxt_sel;
                st_d.base  = nxt_base;
                st_d.limit = nxt_limit;
                st_d.attr  = nxt_attr;
                if (prot && !desc_ar[AR_ACC]) begin
                    st_d.ab_en   = 1'b1;
                    st_d.ab_addr = desc_addr + ADDR_W'(AR_BYTE_OFS);
                    st_d.ab_data = desc_ar | 8'h01;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q             <= '0;
            st_q.fault       <= FK_NONE;
            st_q.limit       <= RST_LIMIT;
            st_q.attr.rd     <= 1'b1;
            st_q.attr.wr     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign done       = st_q.done;
    assign fault_kind = st_q.fault;
    assign err_code   = st_q.err;
    assign cs_sel     = st_q.sel;
    assign cs_base    = st_q.base;
    assign cs_limit   = st_q.limit;
    assign cs_dpl     = st_q.attr.dpl;
    assign cs_rd      = st_q.attr.rd;
    assign cs_wr      = st_q.attr.wr;
    assign cs_exp_dn  = st_q.attr.exp_dn;
    assign cs_conf    = st_q.attr.conf;
    assign cs_big     = st_q.attr.big;
    assign ab_wr_en   = st_q.ab_en;
    assign ab_wr_addr = st_q.ab_addr;
    assign ab_wr_data = st_q.ab_data;
endmodule

// File: rtl/cs_loader_chk.sv
module cs_loader_chk #(
    parameter int ADDR_W  = 32,
    parameter int BASE_W  = 32,
    parameter int LIMIT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [15:0]        new_sel,
    input logic               prot_en,
    input logic               v86,
    input logic [1:0]         cpl,
    input logic               done,
    input logic [1:0]         fault_kind,
    input logic [15:0]        cs_sel,
    input logic [BASE_W-1:0]  cs_base,
    input logic [LIMIT_W-1:0] cs_limit,
    input logic               ab_wr_en,
    input logic [7:0]         ab_wr_data
);
    p_done_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    p_no_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(cs_sel) && $stable(cs_base) && $stable(cs_limit)));

    p_real_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (!prot_en || v86)) |=>
            (cs_base == BASE_W'({$past(new_sel), 4'b0000}) && $stable(cs_limit)
             && fault_kind == 2'd0));

    p_fault_kind_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_kind != 2'd3);

    p_fault_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_kind != 2'd0) |->
            ($stable(cs_sel) && $stable(cs_base) && $stable(cs_limit) && !ab_wr_en));

    p_rpl_stamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && prot_en && !v86) |=> (fault_kind != 2'd0 || cs_sel[1:0] == $past(cpl)));

    p_wb_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ab_wr_en |-> (done && fault_kind == 2'd0 && ab_wr_data[0]));
endmodule

bind cs_loader cs_loader_chk #(
    .ADDR_W  (ADDR_W),
    .BASE_W  (BASE_W),
    .LIMIT_W (LIMIT_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .new_sel    (new_sel),
    .prot_en    (prot_en),
    .v86        (v86),
    .cpl        (cpl),
    .done       (done),
    .fault_kind (fault_kind),
    .cs_sel     (cs_sel),
    .cs_base    (cs_base),
    .cs_limit   (cs_limit),
    .ab_wr_en   (ab_wr_en),
    .ab_wr_data (ab_wr_data)
);

// File: tb/test_cs_loader.sv
`timescale 1ns/1ps
module test_cs_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] new_sel = '0;
    logic        prot_en = 1'b0;
    logic        v86 = 1'b0;
    logic [1:0]  cpl = '0;
    logic        outside_tbl = 1'b0;
    logic [31:0] desc_addr = '0;
    logic [31:0] desc_base = '0;
    logic [31:0] desc_limit = '0;
    logic [7:0]  desc_ar = '0;
    logic        desc_big = 1'b0;
    logic        done;
    logic [1:0]  fault_kind;
    logic [15:0] err_code;
    logic [15:0] cs_sel;
    logic [31:0] cs_base;
    logic [31:0] cs_limit;
    logic [1:0]  cs_dpl;
    logic        cs_rd, cs_wr, cs_exp_dn, cs_conf, cs_big;
    logic        ab_wr_en;
    logic [31:0] ab_wr_addr;
    logic [7:0]  ab_wr_data;

    always #2 clk = ~clk;

    cs_loader i_cs_loader (.*);

    int checks = 0;
    int fails  = 0;

    // expected register contents
    logic [15:0] e_sel   = 16'h0;
    logic [31:0] e_base  = 32'h0;
    logic [31:0] e_limit = 32'hFFFF;
    logic [6:0]  e_attr  = {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_fault(logic pe, logic vm, logic [1:0] c,
                                            logic [15:0] s, logic out, logic [7:0] ar);
        logic [1:0] d;
        d = ar[6:5];
        if (!pe || vm) return 2'd0;
        if (out) return 2'd1;
        if (!(ar[4] && ar[3])) return 2'd1;
        if (ar[2]) begin
            if (d > c) return 2'd1;
        end else begin
            if (s[1:0] > c || d != c) return 2'd1;
        end
        if (!ar[7]) return 2'd2;
        return 2'd0;
    endfunction

    function automatic string req_of(logic pe, logic vm, logic out, logic [7:0] ar,
                                     logic [1:0] f);
        if (!pe || vm) return "R2";
        if (out) return "R4";
        if (!(ar[4] && ar[3])) return "R5";
        if (f == 2'd2) return "R8";
        if (f == 2'd1) return ar[2] ? "R6" : "R7";
        return "R10";
    endfunction

    task automatic do_load(input logic [15:0] s, input logic pe, input logic vm,
                           input logic [1:0] c, input logic out, input logic [31:0] da,
                           input logic [31:0] db, input logic [31:0] dl,
                           input logic [7:0] ar, input logic bg);
        logic [1:0] ef;
        logic       prot;
        logic       ewb;
        string      rq;
        prot = pe && !vm;
        ef = ref_fault(pe, vm, c, s, out, ar);
        rq = req_of(pe, vm, out, ar, ef);
        @(negedge clk);
        new_sel = s; prot_en = pe; v86 = vm; cpl = c; outside_tbl = out;
        desc_addr = da; desc_base = db; desc_limit = dl; desc_ar = ar; desc_big = bg;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ewb = 1'b0;
        if (ef == 2'd0) begin
            if (prot) begin
                e_sel   = {s[15:2], c};
                e_base  = db;
                e_limit = dl;
                e_attr  = {ar[6:5], ar[1], 1'b0, 1'b0, ar[2], bg};
                ewb     = !ar[0];
            end else begin
                e_sel   = s;
                e_base  = {12'h0, s, 4'h0};
                e_attr  = {vm ? 2'd3 : 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
            end
        end
        chk("R1", "done", done, 1);
        chk(rq, "fault_kind", fault_kind, ef);
        chk("R4", "err_code", err_code, ef != 0 ? {s[15:2], 2'b00} : 16'h0);
        chk(ef != 0 ? "R9" : rq, "sel", cs_sel, e_sel);
        chk(ef != 0 ? "R9" : rq, "base", cs_base, e_base);
        chk(ef != 0 ? "R9" : (prot ? "R10" : "R2"), "limit", cs_limit, e_limit);
        chk(ef != 0 ? "R9" : (prot ? "R10" : "R3"), "attr",
            {cs_dpl, cs_rd, cs_wr, cs_exp_dn, cs_conf, cs_big}, e_attr);
        chk("R11", "ab_wr_en", ab_wr_en, ewb);
        if (ewb) begin
            chk("R11", "ab_wr_addr", ab_wr_addr, da + 32'd5);
            chk("R11", "ab_wr_data", ab_wr_data, ar | 8'h01);
        end
        @(negedge clk);
        chk("R1", "done pulse ends", done, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] seed;
        seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "sel", cs_sel, 0);
        chk("R12", "base", cs_base, 0);
        chk("R12", "limit", cs_limit, 32'hFFFF);
        chk("R12", "attr", {cs_dpl, cs_rd, cs_wr, cs_exp_dn, cs_conf, cs_big}, 7'b0011000);
        chk("R12", "done", done, 0);
        chk("R12", "ab_wr_en", ab_wr_en, 0);

        // R2/R3 real mode, limit untouched
        do_load(16'h1234, 0, 0, 2'd0, 0, 32'h100, 32'hDEAD0000, 32'h55, 8'h9B, 1);
        // R2/R3 V86 with outside flag having no effect
        do_load(16'hF00F, 1, 1, 2'd3, 1, 32'h200, 32'h1, 32'h2, 8'h00, 1);
        // R10/R11 conforming OK, DPL<CPL, RPL>CPL, accessed clear
        do_load(16'h0013, 1, 0, 2'd1, 0, 32'h1000, 32'hABC00000, 32'hFFFFF, 8'b1_00_1_1110, 1);
        // R6 conforming DPL>CPL
        do_load(16'h0020, 1, 0, 2'd1, 0, 32'h0, 32'h0, 32'h0, 8'b1_11_1_1110, 0);
        // R7 nonconforming RPL>CPL
        do_load(16'h002B, 1, 0, 2'd2, 0, 32'h0, 32'h0, 32'h0, 8'b1_10_1_1010, 0);
        // R7 nonconforming DPL!=CPL
        do_load(16'h0028, 1, 0, 2'd2, 0, 32'h0, 32'h0, 32'h0, 8'b1_01_1_1010, 0);
        // R4 outside table
        do_load(16'h7FFF, 1, 0, 2'd0, 1, 32'h0, 32'h0, 32'h0, 8'b1_00_1_1010, 0);
        // R5 data type
        do_load(16'h0030, 1, 0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 8'b1_00_1_0010, 0);
        // R5 system type
        do_load(16'h0030, 1, 0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 8'b1_00_0_1010, 0);
        // R8 not present, privilege fine
        do_load(16'h0040, 1, 0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 8'b0_00_1_1010, 0);
        // R8 not present masked by privilege GP (R7)
        do_load(16'h0040, 1, 0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 8'b0_11_1_1010, 0);
        // R11 accessed already set: no write
        do_load(16'h0048, 1, 0, 2'd0, 0, 32'h4000, 32'h77, 32'h88, 8'b1_00_1_1011, 0);

        // R1 idle cycles keep state
        repeat (5) @(negedge clk);
        chk("R1", "idle sel", cs_sel, e_sel);
        chk("R1", "idle base", cs_base, e_base);

        for (int i = 0; i < 600; i++) begin
            logic [7:0] ar;
            ar = 8'($urandom);
            if ($urandom_range(3) != 0) ar[4:3] = 2'b11;
            if ($urandom_range(7) != 0) ar[7] = 1'b1;
            do_load(16'($urandom), 1'($urandom_range(3) != 0), 1'($urandom_range(4) == 0),
                    2'($urandom), 1'($urandom_range(9) == 0), $urandom, $urandom,
                    $urandom, ar, 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule